// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is an SPI slave that answers like a byte-wide serial EEPROM with 16-bit addressing. It runs on a system clock. It synchronises the chip-select, serial clock and serial data lines and rebuilds bytes from them. It then decodes an 8-bit command and moves data between the serial line and an on-chip byte array. The array size is a parameter, and only as many low address bits as the array needs select a location.

Writes collect up to one page of bytes in a buffer. The buffer is copied into the array when chip-select is released on a byte boundary. A self-timed busy interval then starts, and its length is a parameterised number of system clocks. While that interval runs, the block obeys only the status-read command.

A status byte reports the following bits:
- bit 0: busy
- bit 1: the write-enable latch
- bits 2, 3 and 7: three protection bits that software can write

The serial output is released (high impedance) except while the block is sending read data or status.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00, every array location reads 0xFF, and SO is released whenever chip-select is high.
- R2: Command 0x06 sets status bit 1 and command 0x04 clears it. Command 0x05 returns the status byte MSB first, and it returns a fresh copy for every further byte clocked while chip-select stays low.
- R3: Command 0x02 takes a 16-bit address, high byte first and MSB first. The data bytes that follow are stored once chip-select rises. Command 0x03 with an address returns the stored bytes MSB first.
- R4: During a write, only the low 6 address bits advance after each data byte. Past offset 63 they wrap to offset 0 of the same 64-byte page, and a later byte replaces an earlier one at the same location.
- R5: A write is committed only when chip-select rises with no partial byte pending and at least one complete data byte received. Otherwise nothing is stored, no busy interval starts and the enable latch keeps its value.
- R6: A commit raises status bit 0 for exactly WRITE_CLKS system clocks. Bit 0 and bit 1 clear together at the end of that interval.
- R7: While bit 0 is set, every command except 0x05 is ignored: writes store nothing, and reads leave SO released.
- R8: Commands 0x02 and 0x01 have no effect while status bit 1 is clear.
- R9: Command 0x01 followed by one data byte updates only status bits 7, 3 and 2 from the same bit positions of that byte, and then runs a busy interval.
- R10: SO stays released during write and status-write transfers.
- R11: A read keeps incrementing the full address across page boundaries. It wraps from the last array location to location 0.
- R12: Transfers work both with SCK idling low and with SCK idling high, with input sampled on the rising edge and output changed on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sck | input | 1 | Serial clock from the master (asynchronous) |
| si | input | 1 | Serial data in, sampled on SCK rising |
| so | output | 1 | Serial data out, high impedance when not sending |

## Verification
Each serial edge passes two synchroniser flops and an edge detector, so the internal state changes about three system clocks after an SCK edge. An output bit is valid about four clocks after the falling edge that launched it. The bench holds each SCK level for six clocks and samples SO just before the rising edge, which leaves a margin over that delay.

A commit lands about three clocks after CS_n rises, and busy then lasts WRITE_CLKS clocks. The bench observes busy through status bytes at whole-byte granularity and accepts a byte-count window derived from WRITE_CLKS. The exact length is held by a cycle counter in the checker.

// File: rtl/spi_ee_pkg.sv
// Package: command codes and transfer phases shared by the EEPROM slave.
// Assumes 8-bit commands sent MSB first.
package spi_ee_pkg;
    localparam logic [7:0] CMD_STATUS_WR = 8'h01;
    localparam logic [7:0] CMD_WRITE     = 8'h02;
    localparam logic [7:0] CMD_READ      = 8'h03;
    localparam logic [7:0] CMD_WR_LOCK   = 8'h04;
    localparam logic [7:0] CMD_STATUS_RD = 8'h05;
    localparam logic [7:0] CMD_WR_UNLOCK = 8'h06;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADR_HI, PH_ADR_LO, PH_WDATA,
        PH_RDATA, PH_STAT_RD, PH_STAT_WR, PH_IGNORE
    } phase_t;
endpackage

// File: rtl/spi_ee_rx.sv
// Serial front end: synchronises CS_n/SCK/SI into the system clock domain,
// detects SCK edges while selected and assembles bytes MSB first.
// Assumes SCK half period is at least SYNC_STAGES+2 system clocks.
module spi_ee_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    output logic       sel,
    output logic       sel_end_p,
    output logic       sck_fall_p,
    output logic       byte_p,
    output logic [7:0] byte_val,
    output logic [2:0] bit_idx
);
    logic [SYNC_STAGES-1:0] cs_s, sck_s, si_s;
    logic sel_d, sck_d, sck_rise_p;
    logic [6:0] shreg;

    // Purpose: synchroniser chains and one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s  <= '1;
            sck_s <= '0;
            si_s  <= '0;
            sel_d <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            cs_s  <= {cs_s[SYNC_STAGES-2:0], cs_n};
            sck_s <= {sck_s[SYNC_STAGES-2:0], sck};
            si_s  <= {si_s[SYNC_STAGES-2:0], si};
            sel_d <= sel;
            sck_d <= sck_s[SYNC_STAGES-1];
        end
    end

    assign sel        = ~cs_s[SYNC_STAGES-1];
    assign sel_end_p  = sel_d & ~sel;
    assign sck_rise_p = sel & sck_s[SYNC_STAGES-1] & ~sck_d;
    assign sck_fall_p = sel & ~sck_s[SYNC_STAGES-1] & sck_d;
    assign byte_p     = sck_rise_p && (bit_idx == 3'd7);
    assign byte_val   = {shreg, si_s[SYNC_STAGES-1]};

    // Purpose: shift in one bit per rising SCK and count bits in the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            shreg   <= '0;
            bit_idx <= '0;
        end else if (sck_rise_p) begin
            shreg   <= byte_val[6:0];
            bit_idx <= bit_idx + 3'd1;
        end
    end
endmodule

// File: rtl/spi_ee_pagebuf.sv
// Page buffer: one byte slot per page offset plus a filled mask.
// Assumes clr and we are never asserted in the same cycle.
module spi_ee_pagebuf #(
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         we,
    input  logic [OFF_W-1:0]             idx,
    input  logic [7:0]                   din,
    output logic [PAGE_BYTES-1:0][7:0]   data,
    output logic [PAGE_BYTES-1:0]        filled
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Purpose: hold the latest byte for offset g; later bytes overwrite.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                data[g]   <= '0;
                filled[g] <= 1'b0;
            end else if (we && idx == OFF_W'(g)) begin
                data[g]   <= din;
                filled[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_ee_timer.sv
// Self-timed write interval: busy for exactly WRITE_CLKS clocks after start.
// Assumes start is only pulsed while not busy.
module spi_ee_timer #(
    parameter int WRITE_CLKS = 1000,
    localparam int CNT_W = $clog2(WRITE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done_p
);
    logic [CNT_W-1:0] cnt;

    // Purpose: load on start, count down while busy, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(WRITE_CLKS - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done_p = busy && (cnt == '0);
endmodule

// File: rtl/spi_eeprom_slave.sv
// SPI serial EEPROM slave: command decode, 16-bit address capture, page
// buffered writes with in-page wrap, auto-incrementing reads, status byte
// with busy/enable/protect bits and a timed busy lockout.
// Assumes MEM_DEPTH is a power of two, at least PAGE_BYTES and at most 65536.
module spi_eeprom_slave #(
    parameter int MEM_DEPTH   = 256,
    parameter int PAGE_BYTES  = 64,
    parameter int WRITE_CLKS  = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so
);
    import spi_ee_pkg::*;
    localparam int IDX_W = $clog2(MEM_DEPTH);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic sel, sel_end_p, sck_fall_p, byte_p;
    logic [7:0] byte_val;
    logic [2:0] bit_idx;
    phase_t phase;
    logic [15:0] addr;
    logic is_write, wel, busy, done_p, wr_have, sr_have, so_q;
    logic [2:0] bp, sr_bits;
    logic [7:0] tx_byte, status;
    logic [7:0] mem [MEM_DEPTH];
    logic [PAGE_BYTES-1:0][7:0] pb_data;
    logic [PAGE_BYTES-1:0] pb_filled;
    logic commit_wr, commit_sr, wr_start, pb_clr, pb_we;
    logic [IDX_W-1:0] page_base;

    spi_ee_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .sel(sel), .sel_end_p(sel_end_p), .sck_fall_p(sck_fall_p),
        .byte_p(byte_p), .byte_val(byte_val), .bit_idx(bit_idx));

    spi_ee_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pagebuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
        .idx(addr[OFF_W-1:0]), .din(byte_val),
        .data(pb_data), .filled(pb_filled));

    spi_ee_timer #(.WRITE_CLKS(WRITE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_start),
        .busy(busy), .done_p(done_p));

    assign status    = {bp[2], 3'b000, bp[1], bp[0], wel, busy};
    assign commit_wr = sel_end_p && phase == PH_WDATA && wr_have && bit_idx == 3'd0;
    assign commit_sr = sel_end_p && phase == PH_STAT_WR && sr_have && bit_idx == 3'd0;
    assign wr_start  = commit_wr || commit_sr;
    assign pb_clr    = byte_p && phase == PH_CMD && byte_val == CMD_WRITE;
    assign pb_we     = byte_p && phase == PH_WDATA;
    assign page_base = IDX_W'(addr) & ~IDX_W'(PAGE_BYTES - 1);

    // Purpose: transfer phase sequencing, address, latch and status control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CMD; addr <= '0; is_write <= 1'b0; wel <= 1'b0;
            bp <= '0; sr_bits <= '0; wr_have <= 1'b0; sr_have <= 1'b0;
            tx_byte <= '0;
        end else begin
            if (done_p) wel <= 1'b0;
            if (commit_sr) bp <= sr_bits;
            if (!sel) begin
                phase <= PH_CMD; wr_have <= 1'b0; sr_have <= 1'b0;
            end else if (byte_p) begin
                unique case (phase)
                    PH_CMD: begin
                        phase <= PH_IGNORE;
                        if (byte_val == CMD_STATUS_RD) begin
                            tx_byte <= status; phase <= PH_STAT_RD;
                        end else if (!busy) begin
                            unique case (byte_val)
                                CMD_WR_UNLOCK: wel <= 1'b1;
                                CMD_WR_LOCK:   wel <= 1'b0;
                                CMD_STATUS_WR: if (wel) phase <= PH_STAT_WR;
                                CMD_WRITE: if (wel) begin
                                    phase <= PH_ADR_HI; is_write <= 1'b1;
                                end
                                CMD_READ: begin
                                    phase <= PH_ADR_HI; is_write <= 1'b0;
                                end
                                default: ;
                            endcase
                        end
                    end
                    PH_ADR_HI: begin
                        addr[15:8] <= byte_val; phase <= PH_ADR_LO;
                    end
                    PH_ADR_LO: begin
                        if (is_write) begin
                            addr[7:0] <= byte_val; phase <= PH_WDATA;
                        end else begin
                            tx_byte <= mem[IDX_W'({addr[15:8], byte_val})];
                            addr    <= {addr[15:8], byte_val} + 16'd1;
                            phase   <= PH_RDATA;
                        end
                    end
                    PH_WDATA: begin
                        addr[OFF_W-1:0] <= addr[OFF_W-1:0] + 1'b1;
                        wr_have <= 1'b1;
                    end
                    PH_RDATA: begin
                        tx_byte <= mem[IDX_W'(addr)];
                        addr    <= addr + 16'd1;
                    end
                    PH_STAT_RD: tx_byte <= status;
                    PH_STAT_WR: begin
                        sr_bits <= {byte_val[7], byte_val[3], byte_val[2]};
                        sr_have <= 1'b1;
                    end
                    PH_IGNORE: ;
                    default: ;
                endcase
            end
        end
    end

    // Purpose: array storage; erased at reset, page copied in on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit_wr) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pb_filled[i]) mem[page_base | IDX_W'(i)] <= pb_data[i];
        end
    end

    // Purpose: launch the next output bit on each falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n)          so_q <= 1'b0;
        else if (sck_fall_p) so_q <= tx_byte[~bit_idx];
    end

    assign so = (sel && (phase == PH_RDATA || phase == PH_STAT_RD)) ? so_q : 1'bz;
endmodule

// File: rtl/spi_ee_chk.sv
// Checker for the EEPROM slave: busy interval length and origin, latch drop
// at end of busy, and lockout of commits and status changes while busy.
// Bound to every spi_eeprom_slave instance.
module spi_ee_chk #(
    parameter int WRITE_CLKS = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic       wr_start,
    input logic [2:0] bp
);
    int run_len;

    // Purpose: count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_len <= 0;
        else                 run_len <= run_len + 1;
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == WRITE_CLKS));

    assert_busy_from_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_start));

    assert_latch_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_no_commit_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_start);

    assert_protect_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bp));
endmodule

bind spi_eeprom_slave spi_ee_chk #(.WRITE_CLKS(WRITE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel),
    .wr_start(wr_start), .bp(bp));

// File: tb/test_spi_eeprom_slave.sv
// Bench: drives SPI transfers in both clock polarities, keeps an
// arithmetic model of the array and status byte, and compares.
module test_spi_eeprom_slave;
    localparam int DEPTH = 256;
    localparam int WCLK  = 1500;
    localparam int HALF  = 6;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    wire  so_w;
    pullup (so_w);
    bit   mode3 = 1'b0;
    bit   finished = 1'b0;
    int   total = 0, bad = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] wbuf [128];
    logic [7:0] rbuf [512];

    always #5 clk = ~clk;

    spi_eeprom_slave #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(64), .WRITE_CLKS(WCLK))
        i_spi_eeprom_slave (.clk(clk), .rst_n(rst_n), .cs_n(cs_n),
                            .sck(sck), .si(si), .so(so_w));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sel_on();
        sck = mode3; tick(4); cs_n = 1'b0; tick(4);
    endtask

    task automatic sel_off();
        sck = mode3; tick(4); cs_n = 1'b1; tick(8);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
        rx = '1;
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; si = tx[7-i]; tick(HALF);
            rx[7-i] = so_w;
            sck = 1'b1; tick(HALF);
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel_on(); xbyte(op, r, 8); sel_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel_on(); xbyte(8'h05, r, 8); xbyte(8'h00, s, 8); sel_off();
    endtask

    // Poll status within one transfer until ready; report first, last, busy count.
    task automatic wait_ready(output logic [7:0] first, output logic [7:0] last, output int nbusy);
        logic [7:0] r;
        nbusy = 0;
        sel_on(); xbyte(8'h05, r, 8);
        xbyte(8'h00, first, 8); last = first;
        for (int k = 0; k < 60 && last[0]; k++) begin
            nbusy++; xbyte(8'h00, last, 8);
        end
        sel_off();
    endtask

    // Write n bytes from wbuf at a; if upd, apply the in-page wrap to model.
    task automatic do_write(input logic [15:0] a, input int n, input bit upd, input bit chk_so);
        logic [7:0] r;
        sel_on();
        xbyte(8'h02, r, 8); if (chk_so) chk("R10 so released on opcode", r, 8'hFF);
        xbyte(a[15:8], r, 8); xbyte(a[7:0], r, 8);
        for (int k = 0; k < n; k++) begin
            xbyte(wbuf[k], r, 8);
            if (chk_so) chk("R10 so released on data", r, 8'hFF);
        end
        sel_off();
        if (upd)
            for (int k = 0; k < n; k++)
                model[(int'(a) & (DEPTH - 64)) | ((int'(a) + k) & 63)] = wbuf[k];
    endtask

    task automatic do_read(input logic [15:0] a, input int n);
        logic [7:0] r;
        sel_on();
        xbyte(8'h03, r, 8); xbyte(a[15:8], r, 8); xbyte(a[7:0], r, 8);
        for (int k = 0; k < n; k++) xbyte(8'h00, rbuf[k], 8);
        sel_off();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, f;
        int nb;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        tick(5); rst_n = 1'b1; tick(5);

        // R1 reset state
        chk("R1 so released at idle", {7'd0, so_w}, 8'h01);
        rdsr(s); chk("R1 status after reset", s, 8'h00);
        do_read(16'h0000, 4);
        for (int k = 0; k < 4; k++) chk("R1 erased contents", rbuf[k], 8'hFF);

        // R8 write without enable latch
        wbuf[0] = 8'h55; do_write(16'h0010, 1, 0, 0);
        rdsr(s); chk("R8 no busy without latch", s, 8'h00);
        do_read(16'h0010, 1); chk("R8 location unchanged", rbuf[0], 8'hFF);

        // R2 latch set and clear
        cmd1(8'h06); rdsr(s); chk("R2 latch set", s, 8'h02);
        cmd1(8'h04); rdsr(s); chk("R2 latch cleared", s, 8'h00);

        // R3 R10 full page write, R6 busy then latch and busy drop together
        cmd1(8'h06);
        for (int k = 0; k < 64; k++) wbuf[k] = 8'((k * 7 + 3) & 255);
        do_write(16'h0040, 64, 1, 1);
        wait_ready(f, s, nb);
        chk("R6 busy and latch after commit", f, 8'h03);
        chk("R6 latch and busy clear at end", s, 8'h00);
        chk("R6 busy byte count in window", 8'((nb >= 12 && nb <= 17) ? 1 : 0), 8'h01);
        do_read(16'h0040, 64);
        for (int k = 0; k < 64; k++) chk("R3 page readback", rbuf[k], model[64 + k]);

        // R4 R12 wrapping write with SCK idling high
        mode3 = 1'b1;
        cmd1(8'h06);
        for (int k = 0; k < 70; k++) wbuf[k] = 8'(8'hA0 + k);
        do_write(16'h00BC, 70, 1, 0);
        wait_ready(f, s, nb); chk("R4 wrap write committed", f, 8'h03);
        mode3 = 1'b0;

        // R7 lockout while busy
        cmd1(8'h06);
        wbuf[0] = 8'h11; do_write(16'h0000, 1, 1, 0);
        wbuf[0] = 8'h22; do_write(16'h0001, 1, 0, 0);
        do_read(16'h0000, 1); chk("R7 read ignored while busy", rbuf[0], 8'hFF);
        wait_ready(f, s, nb); chk("R7 still busy after ignored cmds", f, 8'h03);
        chk("R7 ready afterwards", s, 8'h00);

        // R5 partial byte and empty write
        cmd1(8'h06);
        sel_on(); xbyte(8'h02, f, 8); xbyte(8'h00, f, 8); xbyte(8'h02, f, 8);
        xbyte(8'h5A, f, 8); xbyte(8'h00, f, 3); sel_off();
        rdsr(s); chk("R5 partial byte no busy", s, 8'h02);
        sel_on(); xbyte(8'h02, f, 8); xbyte(8'h00, f, 8); xbyte(8'h03, f, 8); sel_off();
        rdsr(s); chk("R5 no data no busy", s, 8'h02);
        cmd1(8'h04);
        do_read(16'h0002, 2);
        chk("R5 partial not stored", rbuf[0], 8'hFF);
        chk("R5 empty not stored", rbuf[1], 8'hFF);

        // R9 protection bits
        cmd1(8'h06);
        sel_on(); xbyte(8'h01, f, 8); chk("R10 so released on status write", f, 8'hFF);
        xbyte(8'hFF, f, 8); sel_off();
        wait_ready(f, s, nb);
        chk("R9 status write busy", f, 8'h8F);
        chk("R9 only bits 7 3 2 set", s, 8'h8C);
        sel_on(); xbyte(8'h01, f, 8); xbyte(8'h00, f, 8); sel_off();
        rdsr(s); chk("R8 status write without latch", s, 8'h8C);
        cmd1(8'h06);
        sel_on(); xbyte(8'h01, f, 8); xbyte(8'h73, f, 8); sel_off();
        wait_ready(f, s, nb); chk("R9 other bits not writable", s, 8'h00);

        // R11 R12 R4 R7 full array read, wrapping, SCK idling high
        mode3 = 1'b1;
        do_read(16'h00F0, DEPTH + 2);
        for (int k = 0; k < DEPTH + 2; k++)
            chk("R11 array sweep", rbuf[k], model[(16'hF0 + k) % DEPTH]);
        mode3 = 1'b0;
        chk("R1 so released at end", {7'd0, so_w}, 8'h01);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule